// File: doc/BRIEF.md
# UART Receive Buffer with Fill Trigger and Character Timeout

This block sits between a UART deserialiser and the CPU. The deserialiser offers each received byte through a single-cycle push strobe. The CPU reads bytes from a holding-register port with a single-cycle pop strobe. Whenever the buffer holds data, the byte at its head is shown on the read port. A data-ready line follows the empty state of the buffer.

A control-register write sets up the buffer. One bit switches buffered operation on or off. With buffering off, the block acts as a single holding register. A two-bit field picks the fill level at which a trigger interrupt is raised. A further bit empties the buffer.

Some data may arrive and then stop short of the fill level. A character timeout handles this case: the block counts character-time ticks supplied from outside and raises a timeout interrupt, so the CPU still collects those bytes. If a byte arrives when there is no room, it is dropped and a sticky overrun flag is raised. A status-read pulse clears that flag.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the buffer is empty, `data_ready`, `trig_irq`, `timeout_irq` and `overrun` are low, buffered mode is off and the trigger field is 0.
- R2: Bytes are delivered in arrival order. `data_ready` is high exactly when at least one byte is held, `rd_data` shows the oldest byte, and an accepted pop removes that byte at the clock edge.
- R3: With control bit 0 set the buffer holds up to 16 bytes. With it clear, it holds one byte.
- R4: Control bits 7:6 select the trigger level as 00=1, 01=4, 10=8 and 11=14 bytes. With buffering off, the level is 1. `trig_irq` is high whenever occupancy is at or above the level.
- R5: The timer runs only while occupancy is between 1 and level-1 and no byte was accepted or popped in that cycle. On the 4th `char_tick` counted in that state, `timeout_irq` rises in the next cycle. An accepted push or pop, or leaving that occupancy range, restarts the count.
- R6: Once raised, `timeout_irq` stays high until an accepted pop or a flush, including across further pushes.
- R7: A push while the buffer is full and no pop is accepted in the same cycle is dropped and sets `overrun`. A push and a pop together on a full buffer are both accepted.
- R8: `overrun` stays set until a `status_rd` pulse. If a new overrun happens in the same cycle as the pulse, the flag stays set.
- R9: A control write flushes the buffer if it has bit 1 set, or if it changes bit 0. A flush empties the buffer, clears the timeout state, discards any push or pop in the same cycle, and leaves `overrun` unchanged. The new control values apply from the next cycle.
- R10: A pop on an empty buffer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Received byte strobe from the deserialiser |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Holding-register read strobe |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control value: bit 0 buffered mode, bit 1 flush, bits 7:6 trigger select |
| char_tick | input | 1 | One pulse per character time |
| status_rd | input | 1 | Status-read pulse that clears overrun |
| rd_data | output | 8 | Oldest held byte |
| data_ready | output | 1 | At least one byte held |
| trig_irq | output | 1 | Occupancy at or above trigger level |
| timeout_irq | output | 1 | Character timeout flag |
| overrun | output | 1 | Sticky dropped-byte flag |

## Verification
The bench counts ticks exactly to the fourth one. It also places a push just before the fourth tick. A design with an off-by-one timer, or one that ignores the restart, would raise the timeout one tick early or would never restart. The bench pushes into a full buffer both alone and together with a pop. A design that drops the combined case, or that overwrites the head, would give the wrong order or a false overrun. The bench also issues a flush together with a push, and switches buffered mode on and off while data is held. A design that lets the push through, or keeps stale bytes, would show data_ready high after the flush. Long random runs then mix trigger levels, status reads and pops on an empty buffer.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } rx_trig_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_CLR_BIT  = 1;
  localparam int CTL_TRIG_LSB = 6;

  function automatic int unsigned trig_bytes(rx_trig_e sel);
    case (sel)
      TRIG_1:  trig_bytes = 1;
      TRIG_4:  trig_bytes = 4;
      TRIG_8:  trig_bytes = 8;
      default: trig_bytes = 14;
    endcase
  endfunction

endpackage

// File: rtl/rx_ctl_reg.sv
module rx_ctl_reg
  import uart_rx_fifo_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic             fifo_en,
  output rx_trig_e         trig_sel,
  output logic             flush
);

  logic     en_q, en_d;
  rx_trig_e trig_q, trig_d;

  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    if (wr) begin
      en_d   = wdata[CTL_EN_BIT];
      trig_d = rx_trig_e'(wdata[CTL_TRIG_LSB +: 2]);
    end
  end

  assign flush = wr && (wdata[CTL_CLR_BIT] || (wdata[CTL_EN_BIT] != en_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trig_q <= TRIG_1;
    end else if (wr) begin
      en_q   <= en_d;
      trig_q <= trig_d;
    end
  end

  assign fifo_en  = en_q;
  assign trig_sel = trig_q;

  // R9: a write that changes the enable bit always requests a flush
  a_r9_mode_change_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wdata[CTL_EN_BIT] != en_q)) |-> flush);

endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  input  logic [$clog2(DEPTH+1)-1:0] cap,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full,
  output logic                       push_ok,
  output logic                       pop_ok
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) ptr_inc = '0;
    else                        ptr_inc = p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q >= cap);
  assign pop_ok  = !flush && pop && !empty;
  assign push_ok = !flush && push && (!full || pop_ok);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;

  // R3: occupancy never exceeds the active capacity
  a_r3_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cap);

  // R10: popping an empty store with no push leaves it empty
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);

  // R7: a lone push into a full store does not drain it
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic activity,
  input  logic pop_ok,
  input  logic armed,
  input  logic tick,
  output logic flag
);

  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          fire;

  assign fire = !clear && !activity && armed && tick && (cnt_q == TW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear || activity || !armed) cnt_d = '0;
    else if (tick)                   cnt_d = fire ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (clear || pop_ok) flag_d = 1'b0;
    else if (fire)       flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R5: the flag only rises in the cycle after a qualifying tick
  a_r5_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(tick) && $past(armed)));

  // R6: without a pop or clear the flag is held
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !pop_ok && !clear) |=> flag_q);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              char_tick,
  input  logic              status_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_ready,
  output logic              trig_irq,
  output logic              timeout_irq,
  output logic              overrun
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             fifo_en;
  rx_trig_e         trig_sel;
  logic             flush;
  logic [CNT_W-1:0] cap, lvl, count;
  logic             empty, full, push_ok, pop_ok;
  logic             armed, ovr_set;
  logic             ovr_q, ovr_d;

  rx_ctl_reg #(.CTL_W(8)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .fifo_en  (fifo_en),
    .trig_sel (trig_sel),
    .flush    (flush)
  );

  assign cap = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign lvl = fifo_en ? CNT_W'(trig_bytes(trig_sel)) : CNT_W'(1);

  rx_fifo_store #(.DEPTH(DEPTH), .W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (push_valid),
    .pop     (pop),
    .din     (push_data),
    .cap     (cap),
    .dout    (rd_data),
    .count   (count),
    .empty   (empty),
    .full    (full),
    .push_ok (push_ok),
    .pop_ok  (pop_ok)
  );

  assign armed = !empty && (count < lvl);

  rx_char_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (flush),
    .activity (push_ok || pop_ok),
    .pop_ok   (pop_ok),
    .armed    (armed),
    .tick     (char_tick),
    .flag     (timeout_irq)
  );

  assign ovr_set = !flush && push_valid && !push_ok;

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_set)        ovr_d = 1'b1;
    else if (status_rd) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun    = ovr_q;
  assign data_ready = !empty;
  assign trig_irq   = !empty && (count >= lvl);

  // R9: a flush leaves the buffer empty on the next cycle
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_ready);

  // R8: a status read without a new drop clears the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovr_set) |=> !overrun);

  // R7: overrun is sticky until a status read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !status_rd) |=> overrun);

  // R6: a pending timeout always has data behind it
  a_r6_timeout_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq |-> data_ready);

  // R4: trigger implies data present
  a_r4_trig_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    trig_irq |-> data_ready);

endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;

  localparam time CLK_PERIOD = 10ns;

  logic       clk, rst_n;
  logic       push_valid, pop, ctl_wr, char_tick, status_rd;
  logic [7:0] push_data, ctl_wdata;
  logic [7:0] rd_data;
  logic       data_ready, trig_irq, timeout_irq, overrun;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  uart_rx_fifo i_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop(pop), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .char_tick(char_tick),
    .status_rd(status_rd), .rd_data(rd_data), .data_ready(data_ready),
    .trig_irq(trig_irq), .timeout_irq(timeout_irq), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [7:0] mq[$];
  bit         m_en, m_to, m_ovr;
  bit [1:0]   m_trig;
  int         m_tcnt;

  function automatic int m_cap();
    return m_en ? 16 : 1;
  endfunction

  function automatic int m_lvl();
    if (!m_en) return 1;
    case (m_trig)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model_edge(bit ps, logic [7:0] pd, bit pp, bit wr, logic [7:0] wd,
                            bit tk, bit sr);
    bit flush, do_pop, acc, full, armed;
    int sz;
    sz    = mq.size();
    flush = wr && (wd[1] || (wd[0] != m_en));
    if (flush) begin
      mq.delete();
      m_tcnt = 0;
      m_to   = 0;
      if (sr) m_ovr = 0;
    end else begin
      full   = (sz >= m_cap());
      do_pop = pp && (sz > 0);
      acc    = ps && (!full || do_pop);
      armed  = (sz > 0) && (sz < m_lvl());
      if (do_pop || acc || !armed) m_tcnt = 0;
      else if (tk) begin
        if (m_tcnt == 3) begin m_to = 1; m_tcnt = 0; end
        else m_tcnt++;
      end
      if (do_pop) begin m_to = 0; void'(mq.pop_front()); end
      if (acc) mq.push_back(pd);
      if (ps && !acc) m_ovr = 1;
      else if (sr)    m_ovr = 0;
    end
    if (wr) begin
      m_en   = wd[0];
      m_trig = wd[7:6];
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int sz;
    sz = mq.size();
    chk(tag, "R2 data_ready", int'(data_ready), int'(sz > 0));
    if (sz > 0) chk(tag, "R2 rd_data", int'(rd_data), int'(mq[0]));
    chk(tag, "R4 trig_irq", int'(trig_irq), int'(sz > 0 && sz >= m_lvl()));
    chk(tag, "R5 timeout_irq", int'(timeout_irq), int'(m_to));
    chk(tag, "R7 overrun", int'(overrun), int'(m_ovr));
  endtask

  // drive at negedge, update model at posedge, check at next negedge
  task automatic step(string tag, bit ps, logic [7:0] pd, bit pp, bit wr,
                      logic [7:0] wd, bit tk, bit sr);
    push_valid = ps; push_data = pd; pop = pp; ctl_wr = wr;
    ctl_wdata = wd; char_tick = tk; status_rd = sr;
    @(posedge clk);
    model_edge(ps, pd, pp, wr, wd, tk, sr);
    @(negedge clk);
    push_valid = 0; pop = 0; ctl_wr = 0; char_tick = 0; status_rd = 0;
    check_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 8'h00, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 8'h00, 0, 0, 8'h00, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240517);
    push_valid = 0; push_data = 0; pop = 0; ctl_wr = 0; ctl_wdata = 0;
    char_tick = 0; status_rd = 0;
    m_en = 0; m_trig = 0; m_to = 0; m_ovr = 0; m_tcnt = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "data_ready", int'(data_ready), 0);
    chk("R1", "trig_irq", int'(trig_irq), 0);
    chk("R1", "timeout_irq", int'(timeout_irq), 0);
    chk("R1", "overrun", int'(overrun), 0);

    // R3: non-buffered mode holds one byte; second push overruns
    step("R3", 1, 8'hA1, 0, 0, 8'h00, 0, 0);
    step("R3", 1, 8'hB2, 0, 0, 8'h00, 0, 0);
    chk("R3", "single byte kept", int'(rd_data), 8'hA1);
    step("R8", 0, 8'h00, 1, 0, 8'h00, 0, 1);
    // R10: pop on empty
    step("R10", 0, 8'h00, 1, 0, 8'h00, 0, 0);
    chk("R10", "still empty", int'(data_ready), 0);

    // R3: buffered mode, 16 bytes then overrun on 17th
    step("R9", 0, 8'h00, 0, 1, 8'h01, 0, 0);
    for (int i = 0; i < 17; i++) step("R3", 1, 8'(8'h10 + i), 0, 0, 8'h00, 0, 0);
    chk("R7", "overrun after 17th", int'(overrun), 1);
    // R7: push together with pop on full buffer is accepted
    step("R7", 1, 8'h77, 1, 0, 8'h00, 0, 0);
    // R8: status read and new overrun together keep the flag
    step("R8", 1, 8'h88, 0, 0, 8'h00, 0, 1);
    chk("R8", "set wins", int'(overrun), 1);
    step("R8", 0, 8'h00, 0, 0, 8'h00, 0, 1);
    for (int i = 0; i < 17; i++) step("R2", 0, 8'h00, 1, 0, 8'h00, 0, 0);

    // R4: trigger levels
    for (int t = 0; t < 4; t++) begin
      step("R4", 0, 8'h00, 0, 1, 8'(t << 6) | 8'h03, 0, 0);
      for (int i = 0; i < 15; i++) step("R4", 1, 8'(i * 3), 0, 0, 8'h00, 0, 0);
    end

    // R5: timeout at exactly 4 ticks with restart by a push
    step("R9", 0, 8'h00, 0, 1, 8'hC3, 0, 0);
    step("R5", 1, 8'h51, 0, 0, 8'h00, 0, 0);
    ticks("R5", 3);
    chk("R5", "no timeout after 3", int'(timeout_irq), 0);
    step("R5", 1, 8'h52, 0, 0, 8'h00, 1, 0);
    ticks("R5", 3);
    chk("R5", "restart after push", int'(timeout_irq), 0);
    ticks("R5", 1);
    chk("R5", "timeout after 4", int'(timeout_irq), 1);
    // R6: held across push and idle, cleared by pop
    step("R6", 1, 8'h53, 0, 0, 8'h00, 0, 0);
    idle("R6", 3);
    chk("R6", "held", int'(timeout_irq), 1);
    step("R6", 0, 8'h00, 1, 0, 8'h00, 0, 0);
    chk("R6", "cleared by pop", int'(timeout_irq), 0);

    // R9: flush with simultaneous push; then timeout cleared by flush
    ticks("R9", 4);
    step("R9", 1, 8'h99, 0, 1, 8'hC3, 0, 0);
    chk("R9", "empty after flush", int'(data_ready), 0);
    chk("R9", "timeout cleared", int'(timeout_irq), 0);
    // R9: disabling buffering while holding data flushes
    step("R9", 1, 8'h9A, 0, 0, 8'h00, 0, 0);
    step("R9", 0, 8'h00, 0, 1, 8'h00, 0, 0);
    chk("R9", "mode change flush", int'(data_ready), 0);

    // random phases
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 3000; i++) begin
        bit ps, pp, wr, tk, sr;
        logic [7:0] wd;
        ps = ($urandom % 100) < (ph == 1 ? 70 : 40);
        pp = ($urandom % 100) < (ph == 1 ? 25 : 35);
        wr = ($urandom % 60) == 0;
        tk = ($urandom % 3) == 0;
        sr = ($urandom % 10) == 0;
        wd = {2'($urandom), 4'h0, (($urandom % 8) == 0), (($urandom % 6) != 0)};
        step("R2", ps, 8'($urandom), pp, wr, wd, tk, sr);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule